// File: doc/BRIEF.md
# Mixed-Sign Integer Multiplier Unit

This block is the multiply stage of a 16-bit datapath. Each call takes two operands, a 2-bit sign mode and a width select. It returns the complete product as a 32-bit word, registered on the clock edge that samples the start strobe. Every operand is widened by one bit before it reaches the array. The new top bit is a copy of the operand's sign bit when that operand is treated as signed, and zero when it is treated as unsigned. Because of this, a single 17x17 signed array serves all four sign combinations.

With the width select set to narrow, only the low byte of each operand takes part. The 16-bit result is then extended to 32 bits: with its sign when either operand is signed, and with zeros when both are unsigned. The array produces 34 bits, and the output register keeps the low 32 of them. A valid flag marks the cycle in which a freshly captured product is on the output. Starts may be issued on every cycle.

Top module: `mixmul_top`

## Requirements
- R1: `res_vld` is high in the cycle after a cycle in which `go` was sampled high, and low after any cycle in which `go` was low.
- R2: `res` changes only on a clock edge that samples `go` high. After a cycle with `go` low, `res` keeps its value, whatever the operands, mode and width inputs are doing.
- R3: While `rst_n` is low, `res` is 0 and `res_vld` is 0 (asynchronous, active-low reset).
- R4: `sgn_mode` encodes how the operands are read: 0 means both signed, 1 means both unsigned, 2 means `opa` signed and `opb` unsigned, 3 means `opa` unsigned and `opb` signed. With `narrow`=0 the result is the exact 32-bit product of the two 16-bit operands read that way.
- R5: Unsigned full-width products use all 32 bits, for example 0xFFFF x 0xFFFF gives 0xFFFE0001 in mode 1.
- R6: The signed corners are exact: 0x8000 x 0x8000 gives 0x40000000 in mode 0, and 0x7FFF x 0x7FFF gives 0x3FFF0001.
- R7: Mixed-sign products are exact, for example 0x8000 (signed) x 0xFFFF (unsigned) gives 0x80008000, and 0x8000 (unsigned) x 0xFFFF (signed) gives 0xFFFF8000.
- R8: With `narrow`=1 only bits [7:0] of each operand are used. Bits [15:8] have no effect on `res`.
- R9: With `narrow`=1 the 16-bit result occupies `res`[15:0]. `res`[31:16] holds copies of bit 15 when the mode reads either operand as signed (modes 0, 2, 3), and zeros in mode 1.
- R10: An operand of zero (or a zero low byte when `narrow`=1) gives a result of 0 in every mode.
- R11: With `go` held high on consecutive cycles, each cycle's `res` is the product of the inputs sampled on the preceding edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start strobe: capture a product on this edge |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| sgn_mode | input | 2 | Sign interpretation of the operands (see R4) |
| narrow | input | 1 | 1 selects 8x8 operation on the low bytes, 0 selects 16x16 |
| res | output | 32 | Registered product |
| res_vld | output | 1 | High for one cycle after each start |

## Verification
Two things can happen on the same edge. The output register can be presenting the previous product while it captures the next one. The mode and width inputs can also change at that same edge. The bench keeps `go` high across the whole vector table and the random sweep, and changes sign mode and width between neighbouring entries. Every cycle's `res` is compared against a reference computed for the inputs of the edge just before it, so a stale or mixed-up capture shows up as a mismatch on that entry.

// File: rtl/mixmul_pkg.sv
package mixmul_pkg;

   typedef enum logic [1:0] {
      SGN_SS = 2'd0,
      SGN_UU = 2'd1,
      SGN_SU = 2'd2,
      SGN_US = 2'd3
   } sgn_mode_e;

   function automatic logic first_is_signed(sgn_mode_e m);
      return (m == SGN_SS) || (m == SGN_SU);
   endfunction

   function automatic logic second_is_signed(sgn_mode_e m);
      return (m == SGN_SS) || (m == SGN_US);
   endfunction

endpackage

// File: rtl/mixmul_opext.sv
module mixmul_opext #(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8,
   localparam int EXT_W   = DATA_W + 1
) (
   input  logic [DATA_W-1:0] op,
   input  logic              narrow,
   input  logic              is_signed,
   output logic [EXT_W-1:0]  ext
);

   localparam int PAD_W = DATA_W - NARROW_W;

   logic [DATA_W-1:0] sel;
   logic              top;

   always_comb begin
      if (narrow) begin
         sel = {{PAD_W{is_signed & op[NARROW_W-1]}}, op[NARROW_W-1:0]};
      end else begin
         sel = op;
      end
      top = is_signed & sel[DATA_W-1];
      ext = {top, sel};
   end

endmodule

// File: rtl/mixmul_array.sv
module mixmul_array #(
   parameter int EXT_W       = 17,
   parameter int ARRAY_STYLE = 0,
   localparam int PROD_W     = 2 * EXT_W
) (
   input  logic [EXT_W-1:0]  x,
   input  logic [EXT_W-1:0]  y,
   output logic [PROD_W-1:0] p
);

   generate
      if (ARRAY_STYLE == 0) begin : g_infer
         logic signed [PROD_W-1:0] xs;
         logic signed [PROD_W-1:0] ys;
         assign xs = {{(PROD_W-EXT_W){x[EXT_W-1]}}, x};
         assign ys = {{(PROD_W-EXT_W){y[EXT_W-1]}}, y};
         assign p  = xs * ys;
      end else begin : g_rows
         logic [PROD_W-1:0] xw;
         logic [PROD_W-1:0] acc [EXT_W+1];
         assign xw     = {{(PROD_W-EXT_W){x[EXT_W-1]}}, x};
         assign acc[0] = '0;
         for (genvar i = 0; i < EXT_W; i++) begin : g_row
            logic [PROD_W-1:0] row;
            assign row = y[i] ? (xw << i) : '0;
            if (i == EXT_W - 1) begin : g_neg
               assign acc[i+1] = acc[i] - row;
            end else begin : g_pos
               assign acc[i+1] = acc[i] + row;
            end
         end
         assign p = acc[EXT_W];
      end
   endgenerate

endmodule

// File: rtl/mixmul_pack.sv
module mixmul_pack #(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8,
   localparam int PROD_W  = 2 * (DATA_W + 1),
   localparam int OUT_W   = 2 * DATA_W
) (
   input  logic [PROD_W-1:0] p,
   input  logic              narrow,
   input  logic              any_signed,
   output logic [OUT_W-1:0]  q
);

   localparam int NP_W  = 2 * NARROW_W;
   localparam int FIL_W = OUT_W - NP_W;

   always_comb begin
      if (narrow) begin
         q = {{FIL_W{any_signed & p[NP_W-1]}}, p[NP_W-1:0]};
      end else begin
         q = p[OUT_W-1:0];
      end
   end

endmodule

// File: rtl/mixmul_top.sv
module mixmul_top #(
   parameter int DATA_W      = 16,
   parameter int NARROW_W    = 8,
   parameter int ARRAY_STYLE = 0,
   localparam int EXT_W      = DATA_W + 1,
   localparam int PROD_W     = 2 * EXT_W,
   localparam int OUT_W      = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [1:0]        sgn_mode,
   input  logic              narrow,
   output logic [OUT_W-1:0]  res,
   output logic              res_vld
);
   import mixmul_pkg::*;

   generate
      if (NARROW_W < 1 || NARROW_W >= DATA_W) begin : g_bad_narrow
         $error("mixmul_top: NARROW_W must lie in 1..DATA_W-1");
      end
      if (ARRAY_STYLE != 0 && ARRAY_STYLE != 1) begin : g_bad_style
         $error("mixmul_top: ARRAY_STYLE must be 0 or 1");
      end
   endgenerate

   sgn_mode_e         mode_e;
   logic              a_sgn;
   logic              b_sgn;
   logic [EXT_W-1:0]  a_ext;
   logic [EXT_W-1:0]  b_ext;
   logic [PROD_W-1:0] prod;
   logic [OUT_W-1:0]  packed_q;

   assign mode_e = sgn_mode_e'(sgn_mode);
   assign a_sgn  = first_is_signed(mode_e);
   assign b_sgn  = second_is_signed(mode_e);

   mixmul_opext #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_ext_a (
      .op(opa), .narrow(narrow), .is_signed(a_sgn), .ext(a_ext)
   );

   mixmul_opext #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_ext_b (
      .op(opb), .narrow(narrow), .is_signed(b_sgn), .ext(b_ext)
   );

   mixmul_array #(.EXT_W(EXT_W), .ARRAY_STYLE(ARRAY_STYLE)) u_array (
      .x(a_ext), .y(b_ext), .p(prod)
   );

   mixmul_pack #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_pack (
      .p(prod), .narrow(narrow), .any_signed(a_sgn | b_sgn), .q(packed_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res     <= '0;
         res_vld <= 1'b0;
      end else begin
         res_vld <= go;
         if (go) begin
            res <= packed_q;
         end
      end
   end

endmodule

// File: rtl/mixmul_chk.sv
module mixmul_chk #(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8,
   localparam int OUT_W   = 2 * DATA_W,
   localparam int NP_W    = 2 * NARROW_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              go,
   input logic [DATA_W-1:0] opa,
   input logic [DATA_W-1:0] opb,
   input logic [1:0]        sgn_mode,
   input logic              narrow,
   input logic [OUT_W-1:0]  res,
   input logic              res_vld
);

   a_r1_vld_after_go: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> res_vld);

   a_r1_no_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !go |=> !res_vld);

   a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !go |=> $stable(res));

   a_r3_reset_clear: assert property (@(posedge clk)
      !rst_n |-> (res == '0 && !res_vld));

   a_r9_uns_narrow_zero_top: assert property (@(posedge clk) disable iff (!rst_n)
      (go && narrow && sgn_mode == 2'd1) |=> (res[OUT_W-1:NP_W] == '0));

   a_r9_sgn_narrow_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (go && narrow && sgn_mode != 2'd1) |=>
         ($countones(res[OUT_W-1:NP_W-1]) == 0 ||
          $countones(res[OUT_W-1:NP_W-1]) == OUT_W - NP_W + 1));

   a_r10_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !narrow && (opa == '0 || opb == '0)) |=> (res == '0));

   a_r10_zero_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (go && narrow && (opa[NARROW_W-1:0] == '0 || opb[NARROW_W-1:0] == '0))
         |=> (res == '0));

endmodule

bind mixmul_top mixmul_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .go(go), .opa(opa), .opb(opb),
   .sgn_mode(sgn_mode), .narrow(narrow), .res(res), .res_vld(res_vld)
);

// File: tb/tb_mixmul_top.sv
`timescale 1ns/1ps
module tb_mixmul_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        go;
   logic [15:0] opa, opb;
   logic [1:0]  sgn_mode;
   logic        narrow;
   logic [31:0] res;
   logic        res_vld;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   mixmul_top dut (
      .clk(clk), .rst_n(rst_n), .go(go), .opa(opa), .opb(opb),
      .sgn_mode(sgn_mode), .narrow(narrow), .res(res), .res_vld(res_vld)
   );

   // {opa, opb, mode, narrow, expected}
   localparam int NV = 17;
   localparam logic [66:0] VEC [NV] = '{
      {16'h0003, 16'h0004, 2'd0, 1'b0, 32'h0000000C},
      {16'hFFFF, 16'hFFFF, 2'd0, 1'b0, 32'h00000001},
      {16'hFFFF, 16'hFFFF, 2'd1, 1'b0, 32'hFFFE0001},
      {16'h8000, 16'h8000, 2'd0, 1'b0, 32'h40000000},
      {16'h8000, 16'h8000, 2'd1, 1'b0, 32'h40000000},
      {16'h7FFF, 16'h7FFF, 2'd0, 1'b0, 32'h3FFF0001},
      {16'h8000, 16'hFFFF, 2'd2, 1'b0, 32'h80008000},
      {16'hFFFF, 16'h8000, 2'd3, 1'b0, 32'h80008000},
      {16'h8000, 16'hFFFF, 2'd3, 1'b0, 32'hFFFF8000},
      {16'h0000, 16'hFFFF, 2'd1, 1'b0, 32'h00000000},
      {16'h12FF, 16'h34FF, 2'd0, 1'b1, 32'h00000001},
      {16'h12FF, 16'h34FF, 2'd1, 1'b1, 32'h0000FE01},
      {16'hAB80, 16'hCD7F, 2'd0, 1'b1, 32'hFFFFC080},
      {16'h0080, 16'h00FF, 2'd2, 1'b1, 32'hFFFF8080},
      {16'h0080, 16'h00FF, 2'd3, 1'b1, 32'hFFFFFF80},
      {16'hFF00, 16'h1234, 2'd0, 1'b1, 32'h00000000},
      {16'hFF80, 16'hEE80, 2'd1, 1'b1, 32'h00004000}
   };

   function automatic logic [31:0] ref_mul(logic [15:0] a, logic [15:0] b,
                                           logic [1:0] m, logic n);
      logic   sa, sb;
      longint av, bv;
      sa = (m == 2'd0) || (m == 2'd2);
      sb = (m == 2'd0) || (m == 2'd3);
      if (n) begin
         av = sa ? longint'($signed(a[7:0])) : longint'(a[7:0]);
         bv = sb ? longint'($signed(b[7:0])) : longint'(b[7:0]);
      end else begin
         av = sa ? longint'($signed(a)) : longint'(a);
         bv = sb ? longint'($signed(b)) : longint'(b);
      end
      return 32'(av * bv);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic drive(logic g, logic [15:0] a, logic [15:0] b,
                        logic [1:0] m, logic n);
      go = g; opa = a; opb = b; sgn_mode = m; narrow = n;
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      drive(1'b0, 16'h0, 16'h0, 2'd0, 1'b0);
      repeat (3) @(negedge clk);
      // R3: reset state
      check("R3 res in reset", res, 32'h0);
      check("R3 vld in reset", {31'h0, res_vld}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 R5 R6 R7 R8 R9 R10 R11: table walked with go held high
      for (int i = 0; i < NV; i++) begin
         drive(1'b1, VEC[i][66:51], VEC[i][50:35], VEC[i][34:33], VEC[i][32]);
         @(negedge clk);
         check($sformatf("R4-table R11 entry %0d", i), res, VEC[i][31:0]);
         check("R1 vld back-to-back", {31'h0, res_vld}, 32'h1);
      end

      // R2 R1: idle cycles with changing inputs hold the last result
      drive(1'b0, 16'h1234, 16'h5678, 2'd1, 1'b0);
      @(negedge clk);
      check("R1 vld drops", {31'h0, res_vld}, 32'h0);
      drive(1'b0, 16'hFFFF, 16'h7777, 2'd0, 1'b1);
      @(negedge clk);
      check("R2 res held", res, 32'h00004000);

      // R8: upper bytes ignored in narrow mode
      drive(1'b1, 16'h0005, 16'h00FD, 2'd0, 1'b1);
      @(negedge clk);
      check("R8 low bytes", res, ref_mul(16'h0005, 16'h00FD, 2'd0, 1'b1));
      drive(1'b1, 16'hA505, 16'h3CFD, 2'd0, 1'b1);
      @(negedge clk);
      check("R8 upper bytes ignored", res, 32'hFFFFFFF1);

      // R4 R11: random back-to-back sweep across modes and widths
      for (int k = 0; k < 400; k++) begin
         logic [15:0] ra, rb;
         logic [1:0]  rm;
         logic        rn;
         ra = 16'($urandom);
         rb = 16'($urandom);
         rm = 2'($urandom);
         rn = 1'($urandom);
         if (k % 7 == 0) ra = 16'h8000;
         if (k % 11 == 0) rb = 16'hFFFF;
         if (k % 13 == 0) ra = 16'h0000;
         drive(1'b1, ra, rb, rm, rn);
         @(negedge clk);
         check("R4 R11 random", res, ref_mul(ra, rb, rm, rn));
      end

      // R3: reset in mid-run clears the output
      drive(1'b1, 16'h7FFF, 16'h7FFF, 2'd0, 1'b0);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R3 async clear res", res, 32'h0);
      check("R3 async clear vld", {31'h0, res_vld}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      drive(1'b0, 16'h0, 16'h0, 2'd0, 1'b0);
      @(negedge clk);
      check("R2 no capture without go", res, 32'h0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule